// File: doc/BRIEF.md
# Partial Register Write Merger

This block holds the architectural integer register file of a 64-bit machine whose registers can also be written through narrower views. Each write request carries a register index, a width code and a data word. The block merges the new bits into the stored value according to the width, and it keeps the stored value full-width at all times. The five views are: low byte, bits 15:8, low 16 bits, low 32 bits and the full 64 bits.

A write to the bits-15:8 view leaves a hazard behind. The next full-width read of that register must spend one cycle on an extra merge step before its data is released. The block tracks this with one flag per register. It raises `merge_req` for that single step and then delivers the read data. Two read ports share the register file. While a merge step is in progress, no new read is accepted. Only the first four registers have a bits-15:8 view. A request to any other register through that view is rejected, and so is an undefined width code.

Top module: `partial_reg_merger`

## Requirements
- R1: After a synchronous active-low reset every register reads zero, no merge flag is set, and `wr_illegal`, `merge_req`, `rd0_valid` and `rd1_valid` are low.
- R2: Width code 0 (low byte) replaces bits 7:0 with `wr_data[7:0]` and leaves bits 63:8 unchanged.
- R3: Width code 1 (bits 15:8) replaces bits 15:8 with `wr_data[7:0]`, leaves all other bits unchanged and sets the register's merge flag.
- R4: Width code 2 (16-bit) replaces bits 15:0 with `wr_data[15:0]`, keeps bits 63:16 and leaves the merge flag as it was.
- R5: Width code 3 (32-bit) writes `wr_data[31:0]` to bits 31:0, clears bits 63:32 and clears the merge flag.
- R6: Width code 4 (64-bit) replaces all 64 bits and clears the merge flag, so the next read needs no merge step.
- R7: A width-1 write to an index of 4 or above, or any write with width code 5, 6 or 7, changes no register and no flag, and drives `wr_illegal` high for exactly the next cycle.
- R8: A read of a register whose flag is clear returns its value with `rd_valid` high in the cycle after the request, and `merge_req` stays low.
- R9: A read of a flagged register drives `merge_req` high for exactly one cycle, the cycle after the request. Data with `rd_valid` follows in the cycle after that, and the flag is cleared.
- R10: A read request presented while `merge_req` is high is dropped and never produces `rd_valid`.
- R11: The two read ports may request in the same cycle. When both hit a flagged register, a single merge cycle serves both, and both deliver in the same later cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Register index to write |
| wr_width | input | 3 | Width code 0..4 (see R2 to R6) |
| wr_data | input | 64 | Write data, right-aligned |
| wr_illegal | output | 1 | Previous write was rejected |
| rd0_en | input | 1 | Read request, port 0 |
| rd0_idx | input | 4 | Register index, port 0 |
| rd0_valid | output | 1 | Read data valid, port 0 |
| rd0_data | output | 64 | Full-width read data, port 0 |
| rd1_en | input | 1 | Read request, port 1 |
| rd1_idx | input | 4 | Register index, port 1 |
| rd1_valid | output | 1 | Read data valid, port 1 |
| rd1_data | output | 64 | Full-width read data, port 1 |
| merge_req | output | 1 | Merge step in progress; reads are not accepted |

## Verification
The hardest case to reach from the ports is a read that arrives during the single merge cycle, while another read is still waiting for its merged data. The stimulus first sets a flag with a bits-15:8 write. It then issues a read on port 0 and, in the one cycle where `merge_req` is high, issues a read on port 1. The bench then watches port 1 for two cycles and expects it to stay silent. A second directed case requests the same flagged register on both ports at once, which exercises the shared merge cycle. Flag clearing is checked by a second read of the same register, which must then take the fast path.

// File: rtl/prm_pkg.sv
// Shared width codes for the partial register write merger.
// Assumes a 3-bit width selector; codes 5..7 are undefined and rejected.
package prm_pkg;
    typedef enum logic [2:0] {
        WSEL_LO8 = 3'd0,
        WSEL_HI8 = 3'd1,
        WSEL_W16 = 3'd2,
        WSEL_W32 = 3'd3,
        WSEL_W64 = 3'd4
    } wsel_e;
endpackage

// File: rtl/prm_write_merge.sv
// Combinational merge of a write request into the old register value.
// Produces the new full-width value, legality, and the effect on the merge flag.
// Assumes DATA_W >= 32 and right-aligned write data.
module prm_write_merge #(
    parameter int DATA_W         = 64,
    parameter int IDX_W          = 4,
    parameter int HIGH_VIEW_REGS = 4
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [2:0]        wsel,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] new_val,
    output logic              legal,
    output logic              set_flag,
    output logic              clr_flag
);
    import prm_pkg::*;

    localparam logic [IDX_W-1:0] HV_LIMIT = IDX_W'(HIGH_VIEW_REGS);
    localparam int UPPER_W = DATA_W - 32;

    // Select the merged value and flag effect for the requested view.
    always_comb begin
        new_val  = old_val;
        legal    = 1'b1;
        set_flag = 1'b0;
        clr_flag = 1'b0;
        case (wsel)
            WSEL_LO8: new_val = {old_val[DATA_W-1:8], wdata[7:0]};
            WSEL_HI8: begin
                if (idx < HV_LIMIT) begin
                    new_val  = {old_val[DATA_W-1:16], wdata[7:0], old_val[7:0]};
                    set_flag = 1'b1;
                end else begin
                    legal = 1'b0;
                end
            end
            WSEL_W16: new_val = {old_val[DATA_W-1:16], wdata[15:0]};
            WSEL_W32: begin
                new_val  = {{UPPER_W{1'b0}}, wdata[31:0]};
                clr_flag = 1'b1;
            end
            WSEL_W64: begin
                new_val  = wdata;
                clr_flag = 1'b1;
            end
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/prm_regfile.sv
// Register storage with one merge flag per register.
// A write wins over a merge clear; a flag-neutral write still honours a merge clear.
module prm_regfile #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 64,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [IDX_W-1:0]                 widx,
    input  logic [DATA_W-1:0]                wval,
    input  logic                             set_flag,
    input  logic                             clr_flag,
    input  logic [NUM_REGS-1:0]              merge_clr,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q,
    output logic [NUM_REGS-1:0]              flags_q
);
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        // Update one register and its merge flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[gi]  <= '0;
                flags_q[gi] <= 1'b0;
            end else if (we && widx == IDX_W'(gi)) begin
                regs_q[gi] <= wval;
                if (set_flag)          flags_q[gi] <= 1'b1;
                else if (clr_flag)     flags_q[gi] <= 1'b0;
                else if (merge_clr[gi]) flags_q[gi] <= 1'b0;
            end else if (merge_clr[gi]) begin
                flags_q[gi] <= 1'b0;
            end
        end
    end

    // R5
    w32_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && clr_flag && wval[DATA_W-1:32] == '0) |=> (regs_q[$past(widx)][DATA_W-1:32] == '0));

    // R3
    hi8_keeps_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && set_flag) |=> (regs_q[$past(widx)][DATA_W-1:16] == $past(regs_q[widx][DATA_W-1:16])
                              && flags_q[$past(widx)]));

    // R6
    full_write_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && clr_flag) |=> !flags_q[$past(widx)]);
endmodule

// File: rtl/prm_read_port.sv
// One full-width read port. An unflagged read answers on the next cycle.
// A flagged read spends one merge cycle, clears the flag, then answers.
// Assumes the top stops accepting reads while any port is merging.
module prm_read_port #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 64,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rd_en,
    input  logic [IDX_W-1:0]                 rd_idx,
    input  logic                             accept,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q,
    input  logic [NUM_REGS-1:0]              flags_q,
    output logic                             rd_valid,
    output logic [DATA_W-1:0]                rd_data,
    output logic                             merging,
    output logic [NUM_REGS-1:0]              clr_mask
);
    logic             issue;
    logic [IDX_W-1:0] midx_q;

    assign issue = rd_en && accept;

    // Track a pending merge and register the read result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            merging  <= 1'b0;
            midx_q   <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            merging <= issue && flags_q[rd_idx];
            if (issue) midx_q <= rd_idx;
            if (issue && !flags_q[rd_idx]) begin
                rd_valid <= 1'b1;
                rd_data  <= regs_q[rd_idx];
            end else if (merging) begin
                rd_valid <= 1'b1;
                rd_data  <= regs_q[midx_q];
            end else begin
                rd_valid <= 1'b0;
            end
        end
    end

    // Clear the flag of the register being merged.
    always_comb begin
        clr_mask = '0;
        if (merging) clr_mask[midx_q] = 1'b1;
    end

    // R9
    merge_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        merging |=> (rd_valid && !merging));
endmodule

// File: rtl/partial_reg_merger.sv
// Top: architectural register file with byte, high-byte, 16/32/64-bit write views,
// two read ports, and a one-cycle merge step after a high-byte write.
// Assumes a single writer and that requesters re-issue any read dropped during a merge.
module partial_reg_merger #(
    parameter int NUM_REGS       = 16,
    parameter int DATA_W         = 64,
    parameter int HIGH_VIEW_REGS = 4,
    localparam int IDX_W         = $clog2(NUM_REGS),
    localparam int NUM_RD        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [2:0]        wr_width,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_illegal,
    input  logic              rd0_en,
    input  logic [IDX_W-1:0]  rd0_idx,
    output logic              rd0_valid,
    output logic [DATA_W-1:0] rd0_data,
    input  logic              rd1_en,
    input  logic [IDX_W-1:0]  rd1_idx,
    output logic              rd1_valid,
    output logic [DATA_W-1:0] rd1_data,
    output logic              merge_req
);
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    logic [NUM_REGS-1:0]             flags_q;
    logic [DATA_W-1:0]               merged;
    logic                            wr_legal, set_flag, clr_flag;
    logic [NUM_REGS-1:0]             merge_clr;

    logic [NUM_RD-1:0]               p_en, p_valid, p_merging;
    logic [NUM_RD-1:0][IDX_W-1:0]    p_idx;
    logic [NUM_RD-1:0][DATA_W-1:0]   p_data;
    logic [NUM_RD-1:0][NUM_REGS-1:0] p_clr;

    assign p_en   = {rd1_en, rd0_en};
    assign p_idx  = {rd1_idx, rd0_idx};
    assign rd0_valid = p_valid[0];
    assign rd1_valid = p_valid[1];
    assign rd0_data  = p_data[0];
    assign rd1_data  = p_data[1];
    assign merge_req = |p_merging;

    prm_write_merge #(
        .DATA_W(DATA_W), .IDX_W(IDX_W), .HIGH_VIEW_REGS(HIGH_VIEW_REGS)
    ) i_merge (
        .idx(wr_idx), .wsel(wr_width), .old_val(regs_q[wr_idx]), .wdata(wr_data),
        .new_val(merged), .legal(wr_legal), .set_flag(set_flag), .clr_flag(clr_flag)
    );

    prm_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_rf (
        .clk(clk), .rst_n(rst_n), .we(wr_en && wr_legal), .widx(wr_idx), .wval(merged),
        .set_flag(set_flag), .clr_flag(clr_flag), .merge_clr(merge_clr),
        .regs_q(regs_q), .flags_q(flags_q)
    );

    for (genvar gp = 0; gp < NUM_RD; gp++) begin : g_port
        prm_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_port (
            .clk(clk), .rst_n(rst_n), .rd_en(p_en[gp]), .rd_idx(p_idx[gp]),
            .accept(!merge_req), .regs_q(regs_q), .flags_q(flags_q),
            .rd_valid(p_valid[gp]), .rd_data(p_data[gp]),
            .merging(p_merging[gp]), .clr_mask(p_clr[gp])
        );
    end

    // Combine the flag-clear masks of all ports.
    always_comb begin
        merge_clr = '0;
        for (int k = 0; k < NUM_RD; k++) merge_clr |= p_clr[k];
    end

    // Flag a rejected write for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_illegal <= 1'b0;
        else        wr_illegal <= wr_en && !wr_legal;
    end

    // R7
    illegal_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_legal) |=> (wr_illegal && regs_q[$past(wr_idx)] == $past(regs_q[wr_idx])));

    // R10
    merge_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        merge_req |=> !merge_req);

    // R11
    shared_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_merging == 2'b11) |=> (rd0_valid && rd1_valid));
endmodule

// File: tb/test_partial_reg_merger.sv
module test_partial_reg_merger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [2:0]  wr_width = '0;
    logic [63:0] wr_data = '0;
    logic        wr_illegal;
    logic        rd0_en = 1'b0, rd1_en = 1'b0;
    logic [3:0]  rd0_idx = '0, rd1_idx = '0;
    logic        rd0_valid, rd1_valid, merge_req;
    logic [63:0] rd0_data, rd1_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    partial_reg_merger i_partial_reg_merger (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_width(wr_width),
        .wr_data(wr_data), .wr_illegal(wr_illegal),
        .rd0_en(rd0_en), .rd0_idx(rd0_idx), .rd0_valid(rd0_valid), .rd0_data(rd0_data),
        .rd1_en(rd1_en), .rd1_idx(rd1_idx), .rd1_valid(rd1_valid), .rd1_data(rd1_data),
        .merge_req(merge_req)
    );

    typedef struct packed {
        logic [3:0]  idx;
        logic [2:0]  w;
        logic [63:0] d;
        logic [63:0] e;
        logic        m;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{4'd1,  3'd4, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 1'b0}, // R6
        '{4'd1,  3'd0, 64'hFFFF_FFFF_FFFF_FF55, 64'h0123_4567_89AB_CD55, 1'b0}, // R2
        '{4'd1,  3'd1, 64'hFFFF_FFFF_FFFF_FF77, 64'h0123_4567_89AB_7755, 1'b1}, // R3
        '{4'd1,  3'd2, 64'hFFFF_FFFF_FFFF_BEEF, 64'h0123_4567_89AB_BEEF, 1'b0}, // R4
        '{4'd1,  3'd3, 64'hFFFF_FFFF_DEAD_BEEF, 64'h0000_0000_DEAD_BEEF, 1'b0}, // R5
        '{4'd2,  3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0}, // R6
        '{4'd2,  3'd1, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_00FF, 1'b1}, // R3
        '{4'd2,  3'd3, 64'hAAAA_AAAA_1234_5678, 64'h0000_0000_1234_5678, 1'b0}, // R5
        '{4'd3,  3'd1, 64'h0000_0000_0000_00C3, 64'h0000_0000_0000_C300, 1'b1}, // R3
        '{4'd0,  3'd2, 64'hFFFF_FFFF_FFFF_5A5A, 64'h0000_0000_0000_5A5A, 1'b0}, // R4
        '{4'd15, 3'd4, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, 1'b0}, // R6
        '{4'd15, 3'd0, 64'h0000_0000_0000_007E, 64'h8000_0000_0000_007E, 1'b0}  // R2
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] idx, input logic [2:0] w, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_width = w; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input int port, input logic [3:0] idx, input logic [63:0] exp,
                           input logic m, input string tag);
        @(negedge clk);
        if (port == 0) begin rd0_en = 1'b1; rd0_idx = idx; end
        else           begin rd1_en = 1'b1; rd1_idx = idx; end
        @(negedge clk);
        rd0_en = 1'b0; rd1_en = 1'b0;
        if (!m) begin
            chk({tag, " R8 valid"}, 64'(port == 0 ? rd0_valid : rd1_valid), 64'd1);
            chk({tag, " R8 data"},  port == 0 ? rd0_data : rd1_data, exp);
            chk({tag, " R8 no merge"}, 64'(merge_req), 64'd0);
        end else begin
            chk({tag, " R9 merge_req"}, 64'(merge_req), 64'd1);
            chk({tag, " R9 held"}, 64'(port == 0 ? rd0_valid : rd1_valid), 64'd0);
            @(negedge clk);
            chk({tag, " R9 valid"}, 64'(port == 0 ? rd0_valid : rd1_valid), 64'd1);
            chk({tag, " R9 data"},  port == 0 ? rd0_data : rd1_data, exp);
            chk({tag, " R9 one cycle"}, 64'(merge_req), 64'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 wr_illegal", 64'(wr_illegal), 64'd0);
        chk("R1 merge_req", 64'(merge_req), 64'd0);
        chk("R1 rd valids", 64'({rd0_valid, rd1_valid}), 64'd0);
        rst_n = 1'b1;
        do_read(0, 4'd5, 64'd0, 1'b0, "R1 reg zero");
        do_read(1, 4'd2, 64'd0, 1'b0, "R1 no flag");

        // Vector table walk
        for (int i = 0; i < 12; i++) begin
            do_write(VECS[i].idx, VECS[i].w, VECS[i].d);
            chk($sformatf("vec%0d R7 legal", i), 64'(wr_illegal), 64'd0);
            do_read(i % 2, VECS[i].idx, VECS[i].e, VECS[i].m, $sformatf("vec%0d", i));
        end

        // R7 high-byte view on index 4 is rejected
        do_write(4'd4, 3'd4, 64'h5555_5555_5555_5555);
        do_write(4'd4, 3'd1, 64'h0000_0000_0000_0012);
        chk("R7 illegal hi8 flag", 64'(wr_illegal), 64'd1);
        @(negedge clk);
        chk("R7 illegal one cycle", 64'(wr_illegal), 64'd0);
        do_read(0, 4'd4, 64'h5555_5555_5555_5555, 1'b0, "R7 hi8 suppressed");

        // R7 undefined width code
        do_write(4'd1, 3'd7, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R7 illegal code7", 64'(wr_illegal), 64'd1);
        do_read(1, 4'd1, 64'h0000_0000_DEAD_BEEF, 1'b0, "R7 code7 suppressed");

        // R6 full write clears a pending flag
        do_write(4'd0, 3'd1, 64'h11);
        do_write(4'd0, 3'd4, 64'h42);
        do_read(0, 4'd0, 64'h42, 1'b0, "R6 flag cleared");

        // R5 32-bit write clears a pending flag
        do_write(4'd3, 3'd1, 64'h01);
        do_write(4'd3, 3'd3, 64'hFFFF_FFFF_0000_0007);
        do_read(1, 4'd3, 64'h7, 1'b0, "R5 flag cleared");

        // R4 16-bit write keeps a pending flag
        do_write(4'd2, 3'd1, 64'h99);
        do_write(4'd2, 3'd2, 64'h1357);
        do_read(1, 4'd2, 64'h0000_0000_1234_1357, 1'b1, "R4 flag kept");

        // R11 both ports on one flagged register
        do_write(4'd1, 3'd1, 64'hAA);
        @(negedge clk);
        rd0_en = 1'b1; rd0_idx = 4'd1; rd1_en = 1'b1; rd1_idx = 4'd1;
        @(negedge clk);
        rd0_en = 1'b0; rd1_en = 1'b0;
        chk("R11 merge_req", 64'(merge_req), 64'd1);
        @(negedge clk);
        chk("R11 both valid", 64'({rd0_valid, rd1_valid}), 64'd3);
        chk("R11 port0 data", rd0_data, 64'h0000_0000_DEAD_AAEF);
        chk("R11 port1 data", rd1_data, 64'h0000_0000_DEAD_AAEF);
        chk("R11 one merge", 64'(merge_req), 64'd0);

        // R10 read during merge cycle is dropped
        do_write(4'd0, 3'd1, 64'h33);
        @(negedge clk);
        rd0_en = 1'b1; rd0_idx = 4'd0;
        @(negedge clk);
        rd0_en = 1'b0;
        chk("R10 merge_req", 64'(merge_req), 64'd1);
        rd1_en = 1'b1; rd1_idx = 4'd15;
        @(negedge clk);
        rd1_en = 1'b0;
        chk("R10 port0 data", rd0_data, 64'h3342);
        chk("R10 dropped a", 64'(rd1_valid), 64'd0);
        @(negedge clk);
        chk("R10 dropped b", 64'(rd1_valid), 64'd0);
        do_read(0, 4'd0, 64'h3342, 1'b0, "R9 flag cleared after merge");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule